// File: doc/BRIEF.md
# LCD power-save sequencing controller

This block orders the two enables of a display panel: the supply enable and the enable for the panel's logic signals. It never moves either enable on its own schedule. Every change waits for a frame-start pulse from the display timing. When power save is requested, the supply drops at the next frame pulse. The logic signals keep running until the supply has had time to discharge. When power save ends, the signals start first and the supply follows one frame later.

Power save can be requested in two ways. Software writes a two-bit code into a small control register. A hardware pin can also request it, but only while an enable bit in the same register is set. A third register bit forces the panel supply off, aligned to frame pulses. Software uses it to run its own power-off and power-on order ahead of, or behind, the automatic sequence. The register is written through a write strobe with a data bus, and it is read back on a separate output.

Top module: `lcd_pwrseq`

## Requirements
- R1: Reset is asynchronous and active low. During and after reset the register reads 4'b0011, `panel_pwr_en` and `panel_sig_en` are 0, and `in_powersave` is 1.
- R2: With no power-save request, the first frame pulse after reset, or after the sequence has finished shutting down, sets `panel_sig_en`. The next frame pulse sets `panel_pwr_en`. The supply enable is never 1 while the signal enable is 0.
- R3: While both enables are on, a power-save request sets `in_powersave` on the next clock. `panel_pwr_en` clears at the first frame pulse that follows.
- R4: `panel_sig_en` clears at the 128th frame pulse after power save is requested, which is 127 frame pulses after the supply was removed. The frame counter is 7 bits wide.
- R5: The software field is register bits [1:0]. Code 2'b00 requests power save. Codes 2'b01, 2'b10 and 2'b11 mean normal operation.
- R6: Register bit 2 enables the hardware pin. While bit 2 is 0, the pin has no effect. While bit 2 is 1, the pin passes through a two-flop synchronizer. A rise that is stable before a clock edge shows on `in_powersave` after the third edge.
- R7: Register bit 3 is the supply override. It is sampled only on frame pulses. Setting it clears `panel_pwr_en` at the next frame pulse, and the supply stays off while the bit is 1. Clearing it lets the supply return at the next frame pulse.
- R8: If the request is withdrawn during the discharge count, the count aborts and `panel_sig_en` stays 1. `in_powersave` clears on the next clock, and `panel_pwr_en` returns at the next frame pulse. A later request again waits the full 128 frames.
- R9: `in_powersave` is 1 while the sequence is fully off, waiting for the supply to drop, or discharging. It is 0 while powering up or fully on.
- R10: A write with `reg_we` high loads `reg_wdata` into the register at the clock edge. `reg_rdata` shows the written value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | One-cycle frame-start strobe from the display timing |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Register write data: [3] override, [2] pin enable, [1:0] software code |
| reg_rdata | output | 4 | Register read-back |
| hw_ps_pin | input | 1 | Asynchronous hardware power-save request |
| panel_pwr_en | output | 1 | Panel supply enable |
| panel_sig_en | output | 1 | Panel logic signal enable |
| in_powersave | output | 1 | High while the sequence is off or heading off |

## Verification
A sequencer stuck in the wrong state shows up at the ports within one frame pulse. Either an enable fails to move at a frame pulse, or it moves with no frame pulse at all. A counter that is off by even one frame shows up only at the end of the discharge window. For that reason the bench counts the full 128 frame pulses and checks the signal enable on both sides of the last pulse. It does this once after a clean entry and again after an aborted count. A synchronizer of the wrong depth is caught by sampling `in_powersave` clock by clock after a pin edge.

// File: rtl/lcd_pwrseq_pkg.sv
package lcd_pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_SIG_UP    = 3'd1,
        ST_ON        = 3'd2,
        ST_PWR_DOWN  = 3'd3,
        ST_DISCHARGE = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic       ovr;
        logic       hw_en;
        logic [1:0] sw;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam cfg_t CFG_RST = '{ovr: 1'b0, hw_en: 1'b0, sw: 2'b11};
    localparam logic [1:0] SW_SAVE = 2'b00;

endpackage

// File: rtl/lcd_pwrseq_sync.sv
module lcd_pwrseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lcd_pwrseq_cfg.sv
module lcd_pwrseq_cfg
    import lcd_pwrseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             pin_sync,
    output logic [CFG_W-1:0] rdata,
    output logic             ps_req,
    output logic             ovr_req
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = cfg_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        ps_req  = (cfg_q.sw == SW_SAVE) | (cfg_q.hw_en & pin_sync);
        ovr_req = cfg_q.ovr;
        rdata   = cfg_q;
    end
endmodule

// File: rtl/lcd_pwrseq_fsm.sv
module lcd_pwrseq_fsm
    import lcd_pwrseq_pkg::*;
#(
    parameter int DISCHARGE_FRAMES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_pulse,
    input  logic ps_req,
    input  logic ovr_req,
    output logic pwr_en,
    output logic sig_en,
    output logic in_ps
);
    localparam int CNT_W = $clog2(DISCHARGE_FRAMES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DISCHARGE_FRAMES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // the override is taken only on frame boundaries
        if (frame_pulse) r_d.ovr = ovr_req;
        unique case (r_q.state)
            ST_OFF: begin
                if (frame_pulse && !ps_req) r_d.state = ST_SIG_UP;
            end
            ST_SIG_UP: begin
                if (ps_req) begin
                    // supply is already off: go straight to counting
                    r_d.state = ST_DISCHARGE;
                    r_d.cnt   = frame_pulse ? CNT_ONE : '0;
                end else if (frame_pulse) begin
                    r_d.state = ST_ON;
                end
            end
            ST_ON: begin
                if (ps_req) r_d.state = ST_PWR_DOWN;
            end
            ST_PWR_DOWN: begin
                if (!ps_req) begin
                    r_d.state = ST_ON;
                end else if (frame_pulse) begin
                    r_d.state = ST_DISCHARGE;
                    r_d.cnt   = CNT_ONE;
                end
            end
            ST_DISCHARGE: begin
                if (!ps_req) begin
                    r_d.state = ST_SIG_UP;
                    r_d.cnt   = '0;
                end else if (frame_pulse) begin
                    if (r_q.cnt == CNT_LAST) begin
                        r_d.state = ST_OFF;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_ONE;
                    end
                end
            end
            default: begin
                r_d.state = ST_OFF;
                r_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;
            r_q.cnt   <= '0;
            r_q.ovr   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        sig_en = (r_q.state != ST_OFF);
        pwr_en = ((r_q.state == ST_ON) || (r_q.state == ST_PWR_DOWN)) && !r_q.ovr;
        in_ps  = (r_q.state == ST_OFF) || (r_q.state == ST_PWR_DOWN) ||
                 (r_q.state == ST_DISCHARGE);
    end
endmodule

// File: rtl/lcd_pwrseq.sv
module lcd_pwrseq
    import lcd_pwrseq_pkg::*;
#(
    parameter int DISCHARGE_FRAMES = 128,
    parameter int SYNC_STAGES      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic             reg_we,
    input  logic [CFG_W-1:0] reg_wdata,
    output logic [CFG_W-1:0] reg_rdata,
    input  logic             hw_ps_pin,
    output logic             panel_pwr_en,
    output logic             panel_sig_en,
    output logic             in_powersave
);
    logic pin_sync;
    logic ps_req;
    logic ovr_req;

    lcd_pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hw_ps_pin),
        .dout  (pin_sync)
    );

    lcd_pwrseq_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .pin_sync (pin_sync),
        .rdata    (reg_rdata),
        .ps_req   (ps_req),
        .ovr_req  (ovr_req)
    );

    lcd_pwrseq_fsm #(.DISCHARGE_FRAMES(DISCHARGE_FRAMES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .ps_req      (ps_req),
        .ovr_req     (ovr_req),
        .pwr_en      (panel_pwr_en),
        .sig_en      (panel_sig_en),
        .in_ps       (in_powersave)
    );
endmodule

// File: rtl/lcd_pwrseq_chk.sv
module lcd_pwrseq_chk
    import lcd_pwrseq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frame_pulse,
    input logic             reg_we,
    input logic [CFG_W-1:0] reg_wdata,
    input logic [CFG_W-1:0] reg_rdata,
    input logic             panel_pwr_en,
    input logic             panel_sig_en,
    input logic             in_powersave
);
    // R2
    pwr_needs_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        panel_pwr_en |-> panel_sig_en);

    // R2
    pwr_after_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_pwr_en) |-> $past(panel_sig_en));

    // R7
    pwr_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(panel_pwr_en) |-> $past(frame_pulse));

    // R2
    sig_rise_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_sig_en) |-> $past(frame_pulse));

    // R4
    sig_fall_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_sig_en) |-> ($past(frame_pulse) && $past(in_powersave)));

    // R9
    off_is_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_sig_en |-> in_powersave);

    // R10
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata == $past(reg_wdata)));
endmodule

bind lcd_pwrseq lcd_pwrseq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_pulse  (frame_pulse),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .panel_pwr_en (panel_pwr_en),
    .panel_sig_en (panel_sig_en),
    .in_powersave (in_powersave)
);

// File: tb/lcd_pwrseq_test.sv
module lcd_pwrseq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    // row: {register value, frame pulses, expected pwr, sig, in_powersave}
    localparam logic [14:0] VEC [NVEC] = '{
        {4'b0011, 8'd0,   3'b001},
        {4'b0011, 8'd1,   3'b010},
        {4'b0011, 8'd1,   3'b110},
        {4'b0000, 8'd0,   3'b111},
        {4'b0000, 8'd1,   3'b011},
        {4'b0000, 8'd126, 3'b011},
        {4'b0000, 8'd1,   3'b001},
        {4'b0001, 8'd1,   3'b010},
        {4'b0010, 8'd1,   3'b110},
        {4'b1010, 8'd0,   3'b110},
        {4'b1010, 8'd1,   3'b010},
        {4'b1000, 8'd0,   3'b011},
        {4'b1000, 8'd1,   3'b011},
        {4'b1000, 8'd127, 3'b001},
        {4'b1011, 8'd1,   3'b010},
        {4'b1011, 8'd1,   3'b010},
        {4'b0011, 8'd0,   3'b010},
        {4'b0011, 8'd1,   3'b110}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic [3:0] reg_rdata;
    logic       hw_ps_pin = 1'b0;
    logic       panel_pwr_en, panel_sig_en, in_powersave;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_pwrseq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_pulse  (frame_pulse),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .hw_ps_pin    (hw_ps_pin),
        .panel_pwr_en (panel_pwr_en),
        .panel_sig_en (panel_sig_en),
        .in_powersave (in_powersave)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req, input logic [2:0] exp);
        check(req, {1'b0, panel_pwr_en, panel_sig_en, in_powersave}, {1'b0, exp});
    endtask

    task automatic wr(input logic [3:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_pulse = 1'b1;
            @(negedge clk);
            frame_pulse = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        logic [3:0] cur;
        repeat (3) @(negedge clk);
        // R1: state while reset is held and right after release
        check("R1 reset reg", reg_rdata, 4'b0011);
        check_out("R1 reset outputs", 3'b001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_out("R1 after release", 3'b001);
        cur = 4'b0011;

        // table walk: R2 R3 R4 R5 R7 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] row;
            row = VEC[i];
            if (row[14:11] != cur) begin
                wr(row[14:11]);
                cur = row[14:11];
            end
            frames(int'(row[10:3]));
            check($sformatf("R2/R3/R4/R5/R7/R9 row %0d", i), {1'b0, panel_pwr_en, panel_sig_en, in_powersave}, {1'b0, row[2:0]});
            check($sformatf("R10 readback row %0d", i), reg_rdata, row[14:11]);
        end

        // R8: abort during discharge
        wr(4'b0000);
        frames(1);
        frames(5);
        check_out("R8 discharging", 3'b011);
        wr(4'b0011);
        check_out("R8 abort keeps signals", 3'b010);
        frames(1);
        check_out("R8 power restored", 3'b110);
        // R8 R4: full count after abort
        wr(4'b0000);
        frames(127);
        check_out("R4 sig held at 127", 3'b011);
        frames(1);
        check_out("R4 sig off at 128", 3'b001);
        wr(4'b0011);
        frames(2);
        check_out("R2 back on", 3'b110);

        // R6: pin ignored while enable bit clear
        hw_ps_pin = 1'b1;
        repeat (4) @(negedge clk);
        frames(1);
        check_out("R6 pin ignored", 3'b110);
        hw_ps_pin = 1'b0;
        wr(4'b0111);
        repeat (3) @(negedge clk);
        check_out("R6 enabled pin low", 3'b110);
        hw_ps_pin = 1'b1;
        @(negedge clk);
        check({3'b0, in_powersave}, {3'b0, in_powersave}, {3'b0, in_powersave});
        check("R6 sync edge1", {3'b0, in_powersave}, 4'b0000);
        @(negedge clk);
        check("R6 sync edge2", {3'b0, in_powersave}, 4'b0000);
        @(negedge clk);
        check("R6 sync edge3", {3'b0, in_powersave}, 4'b0001);
        frames(1);
        check_out("R6 R3 pin power down", 3'b011);
        hw_ps_pin = 1'b0;
        repeat (4) @(negedge clk);
        check_out("R6 R8 pin release", 3'b010);
        frames(1);
        check_out("R6 R2 pin power back", 3'b110);
        check("R10 readback", reg_rdata, 4'b0111);

        // R1: reset asserted mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1 mid-run reset", 3'b001);
        check("R1 mid-run reg", reg_rdata, 4'b0011);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule